// File: doc/BRIEF.md
# Byte-Lane Stack Engine for 16-bit Words

This block moves 16-bit words onto and off a stack kept in an external memory that is one byte wide. It owns the stack pointer. It accepts four commands: push a word, pop a word, overwrite the pointer, and report the pointer. Each push or pop is carried out as two byte accesses in consecutive cycles, with one memory access per cycle. A word is always stored with its low byte at the lower address.

The stack grows toward lower addresses. Before each byte is written, the pointer steps down by one. A pop reads upward from the pointer and steps it up by one after each byte. Pointer arithmetic wraps modulo 65536. The pointer is 0 after reset, so the first push lands at the very top of the address space.

A command is offered with `cmd_valid`. It is taken only when the engine is idle. `busy` is high while a push or a pop is in flight. `done` pulses for one cycle when a command finishes, and any word returned by the command is held on `rsp_data` from that cycle on. The memory is expected to be synchronous: read data appears in the cycle after the address is presented.

Top module: `stk_engine`

## Requirements
- R1: After reset the following all read 0: `busy`, `done`, `mem_we`, `mem_re` and `rsp_data`. The stack pointer is also 0.
- R2: The command code is 0 for push. A push writes the high byte of `cmd_data` at SP-1 in the first cycle after acceptance. It writes the low byte at SP-2 in the second cycle. `busy` is high in both cycles, and `done` pulses in the third cycle.
- R3: After a push, the stack pointer equals its old value minus 2.
- R4: The command code is 1 for pop. A pop reads at SP in the first cycle after acceptance and at SP+1 in the second cycle. In the fourth cycle `done` pulses, and `rsp_data` carries {byte at SP+1, byte at SP}. After the pop, the pointer equals its old value plus 2.
- R5: Pointer arithmetic wraps modulo 65536. A push with SP=0 writes 0xFFFF and then 0xFFFE. A pop with SP=0xFFFF reads 0xFFFF and then 0x0000.
- R6: The command code is 2 for load-pointer. It copies `cmd_data` into the pointer. `done` pulses in the next cycle, with no memory access and `busy` staying low.
- R7: The command code is 3 for read-pointer. `done` pulses in the next cycle with `rsp_data` equal to the pointer, and no memory access is made.
- R8: A command offered while `busy` is high is ignored. It changes neither the pointer, nor memory, nor `rsp_data`.
- R9: `done` is high for exactly one cycle per accepted command, and `busy` is low whenever `done` is high.
- R10: `mem_we` and `mem_re` are never high together. Both are low whenever the engine is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command offered this cycle |
| cmd_op | input | 2 | Command code: 0 push, 1 pop, 2 load pointer, 3 read pointer |
| cmd_data | input | 16 | Word to push, or new pointer value |
| rsp_data | output | 16 | Popped word or pointer value, held after `done` |
| busy | output | 1 | Push or pop in flight |
| done | output | 1 | One-cycle completion pulse |
| mem_addr | output | 16 | Byte address to memory |
| mem_wdata | output | 8 | Byte to write |
| mem_we | output | 1 | Write strobe |
| mem_re | output | 1 | Read strobe |
| mem_rdata | input | 8 | Byte read, valid the cycle after the address |

## Verification
The assertions assume that `mem_rdata` returns the addressed byte exactly one cycle after `mem_re`. They also assume that `cmd_op` is only meaningful when `cmd_valid` is high. The bench's memory model returns read data with exactly that one-cycle latency, so the pop checks depend on this timing.

The bench drives inputs only on falling edges. It drops `cmd_valid` in the cycle in which `done` is seen, so that no command is accepted by accident on the edge that returns the engine to idle. During selected pushes and pops, it deliberately holds a load-pointer command on the inputs throughout the busy cycles to test that such commands are ignored.

// File: rtl/stk_pkg.sv
package stk_pkg;
  localparam int STK_AW = 16;
  localparam int STK_BW = 8;
  localparam int STK_WW = 2 * STK_BW;

  typedef enum logic [1:0] {
    OP_PUSH = 2'd0,
    OP_POP  = 2'd1,
    OP_LDSP = 2'd2,
    OP_RDSP = 2'd3
  } stk_op_e;

  typedef enum logic [2:0] {
    S_IDLE    = 3'd0,
    S_PUSH_HI = 3'd1,
    S_PUSH_LO = 3'd2,
    S_POP_LO  = 3'd3,
    S_POP_HI  = 3'd4,
    S_POP_FIN = 3'd5
  } stk_state_e;

  function automatic logic [STK_BW-1:0] upper_byte(input logic [STK_WW-1:0] w);
    return w[STK_WW-1:STK_BW];
  endfunction

  function automatic logic [STK_BW-1:0] lower_byte(input logic [STK_WW-1:0] w);
    return w[STK_BW-1:0];
  endfunction

  function automatic logic [STK_WW-1:0] glue_bytes(input logic [STK_BW-1:0] hi,
                                                   input logic [STK_BW-1:0] lo);
    return {hi, lo};
  endfunction
endpackage

// File: rtl/stk_ptr_reg.sv
module stk_ptr_reg #(
  parameter int AW = stk_pkg::STK_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [AW-1:0] ld_val,
  input  logic          step_dn,
  input  logic          step_up,
  output logic [AW-1:0] sp
);
  localparam logic [AW-1:0] ONE = AW'(1);

  function automatic logic [AW-1:0] minus_one(input logic [AW-1:0] p);
    return p - ONE;
  endfunction

  function automatic logic [AW-1:0] plus_one(input logic [AW-1:0] p);
    return p + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)       sp <= '0;
    else if (ld)      sp <= ld_val;
    else if (step_dn) sp <= minus_one(sp);
    else if (step_up) sp <= plus_one(sp);
  end

  // R5: wrap at both ends of the address space
  p_wrap_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_dn && !ld && sp == '0) |=> sp == '1);
  p_wrap_up_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step_up && !ld && !step_dn && sp == '1) |=> sp == '0);
  // R8: at most one pointer update source at a time
  p_ctl_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ld, step_dn, step_up}));
endmodule

// File: rtl/stk_seq.sv
module stk_seq
  import stk_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output stk_state_e state,
  output logic       busy,
  output logic       accept,
  output logic       ld,
  output logic       step_dn,
  output logic       step_up,
  output logic       cap_push,
  output logic       cap_lo,
  output logic       cap_res,
  output logic       cap_sp,
  output logic       sel_hi,
  output logic       mem_we,
  output logic       mem_re,
  output logic       done,
  output logic       ev_push_hi,
  output logic       ev_push_lo,
  output logic       ev_pop_lo,
  output logic       ev_pop_hi,
  output logic       ev_finish
);
  stk_state_e nxt;
  stk_op_e    op;
  logic       short_cmd;

  assign op        = stk_op_e'(cmd_op);
  assign accept    = cmd_valid && (state == S_IDLE);
  assign short_cmd = accept && (op == OP_LDSP || op == OP_RDSP);

  assign ev_push_hi = (state == S_PUSH_HI);
  assign ev_push_lo = (state == S_PUSH_LO);
  assign ev_pop_lo  = (state == S_POP_LO);
  assign ev_pop_hi  = (state == S_POP_HI);
  assign ev_finish  = ev_push_lo || (state == S_POP_FIN) || short_cmd;

  assign busy     = (state != S_IDLE);
  assign ld       = accept && (op == OP_LDSP);
  assign cap_sp   = accept && (op == OP_RDSP);
  assign cap_push = accept && (op == OP_PUSH);
  assign step_dn  = ev_push_hi || ev_push_lo;
  assign step_up  = ev_pop_lo || ev_pop_hi;
  assign cap_lo   = ev_pop_hi;
  assign cap_res  = (state == S_POP_FIN);
  assign sel_hi   = ev_push_hi;
  assign mem_we   = ev_push_hi || ev_push_lo;
  assign mem_re   = ev_pop_lo || ev_pop_hi;

  always_comb begin
    nxt = state;
    unique case (state)
      S_IDLE: begin
        if (accept && op == OP_PUSH)     nxt = S_PUSH_HI;
        else if (accept && op == OP_POP) nxt = S_POP_LO;
      end
      S_PUSH_HI: nxt = S_PUSH_LO;
      S_PUSH_LO: nxt = S_IDLE;
      S_POP_LO:  nxt = S_POP_HI;
      S_POP_HI:  nxt = S_POP_FIN;
      S_POP_FIN: nxt = S_IDLE;
      default:   nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      done  <= 1'b0;
    end else begin
      state <= nxt;
      done  <= ev_finish;
    end
  end

  // R2: push bytes go out in consecutive cycles, then finish
  p_push_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_hi |=> ev_push_lo);
  // R4: pop runs low read, high read, then gather
  p_pop_order_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_lo |=> ev_pop_hi ##1 (state == S_POP_FIN));
  // R6: short commands complete the next cycle without going busy
  p_short_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    short_cmd |=> (done && !busy));
  // R9: done only when idle, and one pulse per long command
  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);
  p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !$past(short_cmd)) |=> !done || $past(short_cmd));
endmodule

// File: rtl/stk_data.sv
module stk_data
  import stk_pkg::*;
#(
  parameter int AW = STK_AW,
  parameter int BW = STK_BW,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [WW-1:0] push_word,
  input  logic [AW-1:0] sp,
  input  logic [BW-1:0] mem_rdata,
  input  logic          cap_push,
  input  logic          cap_lo,
  input  logic          cap_res,
  input  logic          cap_sp,
  input  logic          sel_hi,
  output logic [BW-1:0] mem_wdata,
  output logic [WW-1:0] rsp_data
);
  logic [WW-1:0] push_q;
  logic [BW-1:0] lo_q;

  assign mem_wdata = sel_hi ? push_q[WW-1:BW] : push_q[BW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      push_q   <= '0;
      lo_q     <= '0;
      rsp_data <= '0;
    end else begin
      if (cap_push) push_q <= push_word;
      if (cap_lo)   lo_q   <= mem_rdata;
      if (cap_res)  rsp_data <= {mem_rdata, lo_q};
      else if (cap_sp) rsp_data <= WW'(sp);
    end
  end

  // R8: the pushed word is frozen while its bytes are being written
  p_push_word_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_hi) |=> $stable(push_q));
endmodule

// File: rtl/stk_engine.sv
module stk_engine
  import stk_pkg::*;
#(
  parameter int AW = STK_AW,
  parameter int BW = STK_BW,
  localparam int WW = 2 * BW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [1:0]    cmd_op,
  input  logic [WW-1:0] cmd_data,
  output logic [WW-1:0] rsp_data,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] mem_addr,
  output logic [BW-1:0] mem_wdata,
  output logic          mem_we,
  output logic          mem_re,
  input  logic [BW-1:0] mem_rdata
);
  stk_state_e    state;
  logic          accept, ld, step_dn, step_up;
  logic          cap_push, cap_lo, cap_res, cap_sp, sel_hi;
  logic          ev_push_hi, ev_push_lo, ev_pop_lo, ev_pop_hi, ev_finish;
  logic [AW-1:0] sp;

  stk_seq u_seq (
    .clk, .rst_n, .cmd_valid, .cmd_op,
    .state, .busy, .accept, .ld, .step_dn, .step_up,
    .cap_push, .cap_lo, .cap_res, .cap_sp, .sel_hi,
    .mem_we, .mem_re, .done,
    .ev_push_hi, .ev_push_lo, .ev_pop_lo, .ev_pop_hi, .ev_finish
  );

  stk_ptr_reg #(.AW(AW)) u_ptr (
    .clk, .rst_n, .ld, .ld_val(AW'(cmd_data)), .step_dn, .step_up, .sp
  );

  stk_data #(.AW(AW), .BW(BW)) u_data (
    .clk, .rst_n, .push_word(cmd_data), .sp, .mem_rdata,
    .cap_push, .cap_lo, .cap_res, .cap_sp, .sel_hi,
    .mem_wdata, .rsp_data
  );

  // pre-decrement on writes, plain pointer on reads
  assign mem_addr = mem_we ? (sp - AW'(1)) : sp;

  // R2: low byte goes one address below the high byte
  p_push_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_lo |-> mem_addr == $past(mem_addr) - AW'(1));
  // R4: high byte is read one address above the low byte
  p_pop_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_pop_hi |-> mem_addr == $past(mem_addr) + AW'(1));
  // R10: strobes exclusive and quiet when idle
  p_mem_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!mem_we && !mem_re));
  // R3: a push leaves the pointer two below where it started
  p_push_net_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_push_lo |=> sp == $past(sp, 2) - AW'(2));
endmodule

// File: tb/sim_stk_engine.sv
module sim_stk_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] cmd_data = 16'd0;
  logic [15:0] rsp_data;
  logic        busy, done, mem_we, mem_re;
  logic [15:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  stk_engine u0 (
    .clk, .rst_n, .cmd_valid, .cmd_op, .cmd_data, .rsp_data,
    .busy, .done, .mem_addr, .mem_wdata, .mem_we, .mem_re, .mem_rdata
  );

  // synchronous byte memory, aliased on the low address byte
  logic [7:0] bmem [256];
  always_ff @(posedge clk) begin
    if (mem_we) bmem[mem_addr[7:0]] <= mem_wdata;
    mem_rdata <= bmem[mem_addr[7:0]];
  end

  // reference model
  logic [15:0] ref_sp;
  logic [7:0]  ref_mem [256];

  function automatic logic [15:0] word_of(input logic [7:0] h, input logic [7:0] l);
    return (16'(h) << 8) | 16'(l);
  endfunction

  // observation record from the last command
  logic [15:0] w_addr [4];
  logic [7:0]  w_dat  [4];
  logic [15:0] r_addr [4];
  int nw, nr, ncyc, busy_bad;

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_cmd(input logic [1:0] op, input logic [15:0] d, input bit spurious);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
    @(negedge clk);
    if (spurious) begin
      cmd_valid = 1'b1; cmd_op = 2'd2; cmd_data = 16'hBEEF;
    end else cmd_valid = 1'b0;
    nw = 0; nr = 0; ncyc = 0; busy_bad = 0;
    for (int k = 0; k < 10; k++) begin
      ncyc++;
      if (mem_we && nw < 4) begin w_addr[nw] = mem_addr; w_dat[nw] = mem_wdata; nw++; end
      if (mem_re && nr < 4) begin r_addr[nr] = mem_addr; nr++; end
      if (done) begin
        if (busy) busy_bad++;
        break;
      end
      if ((op == 2'd0 || op == 2'd1) && !busy) busy_bad++;
      @(negedge clk);
    end
    cmd_valid = 1'b0;
  endtask

  task automatic after_done;
    @(negedge clk);
    chk(!done, "R9 done single pulse", 32'(done), 32'd0);
  endtask

  task automatic do_push(input logic [15:0] d, input bit spurious);
    logic [15:0] a1, a2;
    a1 = ref_sp - 16'd1; a2 = ref_sp - 16'd2;
    run_cmd(2'd0, d, spurious);
    chk(ncyc == 3, "R2 push cycles", 32'(ncyc), 32'd3);
    chk(nw == 2 && nr == 0, "R2 push access count", 32'(nw), 32'd2);
    chk(w_addr[0] == a1 && w_dat[0] == d[15:8], "R2 push high byte",
        {w_addr[0], 8'h0, w_dat[0]}, {a1, 8'h0, d[15:8]});
    chk(w_addr[1] == a2 && w_dat[1] == d[7:0], "R2 push low byte",
        {w_addr[1], 8'h0, w_dat[1]}, {a2, 8'h0, d[7:0]});
    chk(busy_bad == 0, "R9 busy during push / low at done", 32'(busy_bad), 32'd0);
    ref_mem[a1[7:0]] = d[15:8];
    ref_mem[a2[7:0]] = d[7:0];
    ref_sp = a2;
    after_done();
  endtask

  task automatic do_pop(input bit spurious);
    logic [15:0] exp;
    logic [15:0] a0, a1;
    a0 = ref_sp; a1 = ref_sp + 16'd1;
    exp = word_of(ref_mem[a1[7:0]], ref_mem[a0[7:0]]);
    run_cmd(2'd1, 16'h0, spurious);
    chk(ncyc == 4, "R4 pop cycles", 32'(ncyc), 32'd4);
    chk(nr == 2 && nw == 0, "R10 pop makes no write", 32'(nw), 32'd0);
    chk(r_addr[0] == a0 && r_addr[1] == a1, "R4 pop addresses",
        {r_addr[0], r_addr[1]}, {a0, a1});
    chk(rsp_data == exp, "R4 popped word", 32'(rsp_data), 32'(exp));
    chk(busy_bad == 0, "R9 busy during pop / low at done", 32'(busy_bad), 32'd0);
    ref_sp = ref_sp + 16'd2;
    after_done();
  endtask

  task automatic do_load(input logic [15:0] d);
    run_cmd(2'd2, d, 1'b0);
    chk(ncyc == 1 && nw == 0 && nr == 0, "R6 load pointer one cycle, no access",
        32'(ncyc), 32'd1);
    ref_sp = d;
    after_done();
  endtask

  task automatic do_read(input string req);
    run_cmd(2'd3, 16'h0, 1'b0);
    chk(ncyc == 1 && nw == 0 && nr == 0, "R7 read pointer one cycle, no access",
        32'(ncyc), 32'd1);
    chk(rsp_data == ref_sp, req, 32'(rsp_data), 32'(ref_sp));
    after_done();
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) begin bmem[i] = 8'h00; ref_mem[i] = 8'h00; end
    ref_sp = 16'h0000;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !done, "R1 reset busy/done", {busy, done}, 2'b00);
    chk(!mem_we && !mem_re, "R1 reset strobes (R10 idle quiet)", {mem_we, mem_re}, 2'b00);
    chk(rsp_data == 16'h0, "R1 reset rsp_data", 32'(rsp_data), 32'd0);
    do_read("R1 pointer zero after reset");

    // R5 first push wraps to the top of memory
    do_push(16'hA55A, 1'b0);
    do_read("R3 pointer after push");
    // R8 load offered during pop is ignored; R5 pointer returns to zero
    do_pop(1'b1);
    do_read("R8 pointer unchanged by ignored load (R5 wrap to 0)");

    // R5 wrap across 0x0000/0xFFFF
    do_load(16'h0001);
    do_read("R6 pointer after load");
    do_push(16'h1234, 1'b1);
    do_read("R8 pointer after push with ignored load");
    do_load(16'hFFFF);
    do_load(16'h0001);
    ref_sp = 16'hFFFF;
    do_load(16'hFFFF);
    do_pop(1'b0);
    do_read("R5 pointer wraps up past 0xFFFF");

    // nested pushes, popped in reverse
    do_load(16'h0080);
    do_push(16'h0102, 1'b0);
    do_push(16'hFEDC, 1'b0);
    do_pop(1'b0);
    do_pop(1'b0);
    do_read("R3 pointer restored after balanced push/pop");

    // constrained random mix
    for (int n = 0; n < 400; n++) begin
      int sel;
      sel = int'($urandom % 10);
      if (sel < 4)      do_push(16'($urandom), ($urandom % 4) == 0);
      else if (sel < 8) do_pop(($urandom % 4) == 0);
      else if (sel < 9) do_load(16'($urandom));
      else              do_read("R7 random read pointer");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule